// File: doc/BRIEF.md
# Hamming single-error-correcting word codec

This block protects 32-bit words with six Hamming check bits. It is purely combinational. On the write side it turns a data word into six even-parity check bits, which are stored next to the data. On the read side it takes the 38 stored bits and recomputes the check bits from the stored data. It XORs the recomputed bits with the stored ones to form a six-bit syndrome, which names the position of a flipped bit.

The syndrome is decoded into a one-hot location vector. Each data output bit passes through a two-way select that picks either the stored bit or its inverse, steered by that bit's location line.

Codeword positions run from 1 to 38. Check bit k sits at position 2^k (positions 1, 2, 4, 8, 16 and 32). Data bit 0 sits at position 3, and the other data bits fill the remaining positions in ascending order (5, 6, 7, 9 to 15, 17 to 31, 33 to 38). Read and write paths are independent and may be used in the same cycle.

Top module: `hsec_codec`

## Requirements
- R1: `wr_check[k]` equals the XOR of every `wr_data` bit whose codeword position has bit k set, for k = 0..5. Data bit i maps to the i-th non-power-of-two position, counting from position 3 for i = 0.
- R2: When `rd_check` equals the check bits of `rd_data` (syndrome 0), `rd_fixed` equals `rd_data`, and `err_fixed` and `err_fatal` are both 0. This includes the all-zero word.
- R3: When exactly one data bit of a valid codeword is inverted, `rd_fixed` equals the original data word, `err_fixed` is 1 and `err_fatal` is 0. This holds for all 32 data positions.
- R4: When exactly one check bit of a valid codeword is inverted, `rd_fixed` equals `rd_data` unchanged, `err_fixed` is 1 and `err_fatal` is 0. This holds for all 6 check positions.
- R5: A syndrome value from 39 to 63 sets `err_fatal` to 1 and `err_fixed` to 0, and `rd_fixed` equals `rd_data` unchanged.
- R6: For any read input, `rd_fixed` differs from `rd_data` in at most one bit, and `err_fixed` and `err_fatal` are never both 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_data | input | 32 | Data word being written |
| wr_check | output | 6 | Check bits to store beside `wr_data` |
| rd_data | input | 32 | Data part of the stored codeword |
| rd_check | input | 6 | Check part of the stored codeword |
| rd_fixed | output | 32 | Corrected read data |
| err_fixed | output | 1 | Syndrome named a codeword position from 1 to 38 |
| err_fatal | output | 1 | Syndrome above 38; data passed through as stored |

## Verification
The bench flips every one of the 38 positions of many random codewords. A wrong position map or parity mask would make it correct the wrong bit and leave two bits bad, and a decoder that is off by one would misplace every fix. Check-bit flips are tried on their own, since a design that routed power-of-two locations into the data select would corrupt a clean data word. Every syndrome from 39 to 63 is forced, to catch a limit comparison that is off by one or wraps and so flags a fix instead of a fatal error. Double flips confirm that no input ever inverts more than one data bit or raises both flags.

// File: rtl/hsec_pkg.sv
`timescale 1ns/1ps
package hsec_pkg;
  localparam int HS_DATA_W = 32;
  localparam int HS_CHK_W  = 6;
  localparam int HS_CODE_W = HS_DATA_W + HS_CHK_W;

  // True for 1, 2, 4, 8, ...: the slots reserved for check bits.
  function automatic bit hs_is_pow2(int p);
    return (p > 0) && ((p & (p - 1)) == 0);
  endfunction

  // Codeword position (1-based) of data bit idx.
  function automatic int hs_data_pos(int idx);
    int res;
    int cnt;
    res = 0;
    cnt = 0;
    for (int p = 1; p < 128; p++) begin
      if (!hs_is_pow2(p)) begin
        if (cnt == idx) res = p;
        cnt++;
      end
    end
    return res;
  endfunction

  // Data bits covered by check bit k: those whose position has bit k set.
  function automatic logic [63:0] hs_cover_mask(int k, int dw);
    logic [63:0] m;
    m = '0;
    for (int i = 0; i < 64; i++) begin
      if (i < dw) m[i] = ((hs_data_pos(i) >> k) & 1) != 0;
    end
    return m;
  endfunction

  // Location-vector bits (index p-1) that name check-bit positions.
  function automatic logic [63:0] hs_check_loc_mask(int cw);
    logic [63:0] m;
    m = '0;
    for (int p = 1; p <= 64; p++) begin
      if (p <= cw) m[p-1] = hs_is_pow2(p);
    end
    return m;
  endfunction
endpackage

// File: rtl/hsec_encoder.sv
`timescale 1ns/1ps
module hsec_encoder
  import hsec_pkg::*;
#(
  parameter int DATA_W = HS_DATA_W,
  parameter int CHK_W  = HS_CHK_W
) (
  input  logic [DATA_W-1:0] data,
  output logic [CHK_W-1:0]  check
);
  for (genvar k = 0; k < CHK_W; k++) begin : g_chk
    localparam logic [63:0] COVER = hs_cover_mask(k, DATA_W);
    assign check[k] = ^(data & COVER[DATA_W-1:0]);
  end
endmodule

// File: rtl/hsec_syndrome.sv
`timescale 1ns/1ps
module hsec_syndrome
  import hsec_pkg::*;
#(
  parameter int DATA_W = HS_DATA_W,
  parameter int CHK_W  = HS_CHK_W
) (
  input  logic [DATA_W-1:0] st_data,
  input  logic [CHK_W-1:0]  st_check,
  output logic [CHK_W-1:0]  syn
);
  logic [CHK_W-1:0] recomputed;

  hsec_encoder #(.DATA_W(DATA_W), .CHK_W(CHK_W)) i_recalc (
    .data  (st_data),
    .check (recomputed)
  );

  assign syn = recomputed ^ st_check;
endmodule

// File: rtl/hsec_locator.sv
`timescale 1ns/1ps
module hsec_locator
  import hsec_pkg::*;
#(
  parameter int CHK_W  = HS_CHK_W,
  parameter int CODE_W = HS_CODE_W
) (
  input  logic [CHK_W-1:0]  syn,
  output logic [CODE_W-1:0] loc,
  output logic              hit,
  output logic              fatal
);
  localparam logic [CHK_W-1:0] LIMIT = CHK_W'(CODE_W);

  for (genvar p = 1; p <= CODE_W; p++) begin : g_loc
    assign loc[p-1] = (syn == CHK_W'(p));
  end

  assign hit   = (syn != '0) && (syn <= LIMIT);
  assign fatal = (syn > LIMIT);

  always_comb begin
    assert_loc_onehot_R6: assert ($onehot0(loc))
      else $error("location vector has more than one line set");
    assert_flags_exclusive_R6: assert (!(hit && fatal))
      else $error("fixed and fatal both raised");
    if (fatal) begin
      assert_fatal_no_loc_R5: assert (loc == '0)
        else $error("fatal syndrome still selects a location");
    end
    if (hit) begin
      assert_hit_has_loc_R3: assert ($countones(loc) == 1)
        else $error("in-range syndrome selects no location");
    end
  end
endmodule

// File: rtl/hsec_fixer.sv
`timescale 1ns/1ps
module hsec_fixer
  import hsec_pkg::*;
#(
  parameter int DATA_W = HS_DATA_W,
  parameter int CODE_W = HS_CODE_W
) (
  input  logic [DATA_W-1:0] st_data,
  input  logic [CODE_W-1:0] loc,
  output logic [DATA_W-1:0] fixed
);
  localparam logic [63:0] CHK_LOCS = hs_check_loc_mask(CODE_W);

  logic [DATA_W-1:0] flip_sel;

  for (genvar i = 0; i < DATA_W; i++) begin : g_mux
    localparam int POS = hs_data_pos(i);
    assign flip_sel[i] = loc[POS-1];
    assign fixed[i]    = flip_sel[i] ? ~st_data[i] : st_data[i];
  end

  always_comb begin
    assert_one_flip_R6: assert ($countones(fixed ^ st_data) <= 1)
      else $error("more than one data bit inverted");
    if ((loc & CHK_LOCS[CODE_W-1:0]) != '0) begin
      assert_check_loc_keeps_data_R4: assert (fixed == st_data)
        else $error("check-bit location altered data");
    end
  end
endmodule

// File: rtl/hsec_codec.sv
`timescale 1ns/1ps
module hsec_codec
  import hsec_pkg::*;
#(
  parameter int DATA_W = HS_DATA_W,
  parameter int CHK_W  = HS_CHK_W
) (
  input  logic [DATA_W-1:0] wr_data,
  output logic [CHK_W-1:0]  wr_check,
  input  logic [DATA_W-1:0] rd_data,
  input  logic [CHK_W-1:0]  rd_check,
  output logic [DATA_W-1:0] rd_fixed,
  output logic              err_fixed,
  output logic              err_fatal
);
  localparam int CODE_W = DATA_W + CHK_W;

  logic [CHK_W-1:0]  syn;
  logic [CODE_W-1:0] loc;

  hsec_encoder #(.DATA_W(DATA_W), .CHK_W(CHK_W)) i_wr_enc (
    .data  (wr_data),
    .check (wr_check)
  );

  hsec_syndrome #(.DATA_W(DATA_W), .CHK_W(CHK_W)) i_syn (
    .st_data  (rd_data),
    .st_check (rd_check),
    .syn      (syn)
  );

  hsec_locator #(.CHK_W(CHK_W), .CODE_W(CODE_W)) i_loc (
    .syn   (syn),
    .loc   (loc),
    .hit   (err_fixed),
    .fatal (err_fatal)
  );

  hsec_fixer #(.DATA_W(DATA_W), .CODE_W(CODE_W)) i_fix (
    .st_data (rd_data),
    .loc     (loc),
    .fixed   (rd_fixed)
  );

  always_comb begin
    if (syn == '0) begin
      assert_clean_pass_R2: assert (rd_fixed == rd_data && !err_fixed && !err_fatal)
        else $error("clean codeword altered or flagged");
    end
    if (err_fatal) begin
      assert_fatal_pass_R5: assert (rd_fixed == rd_data)
        else $error("fatal word was modified");
    end
  end
endmodule

// File: tb/test_hsec_codec.sv
`timescale 1ns/1ps
module test_hsec_codec;
  logic        clk = 1'b0;
  logic [31:0] wr_data = '0;
  logic [5:0]  wr_check;
  logic [31:0] rd_data = '0;
  logic [5:0]  rd_check = '0;
  logic [31:0] rd_fixed;
  logic        err_fixed;
  logic        err_fatal;

  int tests = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  hsec_codec i_hsec_codec (
    .wr_data   (wr_data),
    .wr_check  (wr_check),
    .rd_data   (rd_data),
    .rd_check  (rd_check),
    .rd_fixed  (rd_fixed),
    .err_fixed (err_fixed),
    .err_fatal (err_fatal)
  );

  // Model: check bits equal the XOR of the positions of all set data bits.
  function automatic logic [5:0] model_check(logic [31:0] d);
    logic [5:0] acc;
    int cnt;
    acc = '0;
    cnt = 0;
    for (int p = 1; p <= 38; p++) begin
      if ((p & (p - 1)) != 0) begin
        if (d[cnt]) acc = acc ^ 6'(p);
        cnt++;
      end
    end
    return acc;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [31:0] wd, input logic [31:0] rd, input logic [5:0] rc);
    @(posedge clk);
    #1;
    wr_data  = wd;
    rd_data  = rd;
    rd_check = rc;
    @(negedge clk);
  endtask

  task automatic t_idle();
    drive('0, '0, '0);
    chk(wr_check == 6'd0, "R1 zero word check", 64'(wr_check), 64'd0);
    chk(rd_fixed == '0 && !err_fixed && !err_fatal, "R2 zero word read",
        {29'd0, err_fixed, err_fatal, rd_fixed}, 64'd0);
  endtask

  task automatic t_encode();
    logic [31:0] w;
    for (int n = 0; n < 44; n++) begin
      if (n < 32) w = 32'd1 << n;
      else if (n == 32) w = 32'hffff_ffff;
      else if (n == 33) w = 32'haaaa_5555;
      else w = $urandom;
      drive(w, '0, '0);
      chk(wr_check == model_check(w), "R1 encode", 64'(wr_check), 64'(model_check(w)));
    end
  endtask

  task automatic t_clean();
    logic [31:0] w;
    for (int n = 0; n < 12; n++) begin
      w = (n == 0) ? 32'hffff_ffff : $urandom;
      drive('0, w, model_check(w));
      chk(rd_fixed == w && !err_fixed && !err_fatal, "R2 clean read",
          {30'd0, err_fixed, err_fatal, rd_fixed}, {32'd0, w});
    end
  endtask

  task automatic t_data_flips();
    logic [31:0] w;
    logic [31:0] bad;
    for (int n = 0; n < 16; n++) begin
      w = (n == 0) ? 32'd0 : $urandom;
      for (int i = 0; i < 32; i++) begin
        bad = w ^ (32'd1 << i);
        drive('0, bad, model_check(w));
        chk(rd_fixed == w, "R3 data bit recovered", 64'(rd_fixed), 64'(w));
        chk(err_fixed && !err_fatal, "R3 flags", {62'd0, err_fixed, err_fatal}, 64'd2);
      end
    end
  endtask

  task automatic t_check_flips();
    logic [31:0] w;
    for (int n = 0; n < 16; n++) begin
      w = $urandom;
      for (int k = 0; k < 6; k++) begin
        drive('0, w, model_check(w) ^ (6'd1 << k));
        chk(rd_fixed == w, "R4 data untouched", 64'(rd_fixed), 64'(w));
        chk(err_fixed && !err_fatal, "R4 flags", {62'd0, err_fixed, err_fatal}, 64'd2);
      end
    end
  endtask

  task automatic t_fatal();
    logic [31:0] w;
    for (int s = 39; s < 64; s++) begin
      w = $urandom;
      drive('0, w, model_check(w) ^ 6'(s));
      chk(err_fatal && !err_fixed, "R5 fatal flags", {62'd0, err_fixed, err_fatal}, 64'd1);
      chk(rd_fixed == w, "R5 data passed", 64'(rd_fixed), 64'(w));
    end
  endtask

  task automatic t_double();
    logic [31:0] w;
    logic [31:0] bad;
    int a;
    int b;
    for (int n = 0; n < 40; n++) begin
      w = $urandom;
      a = n % 32;
      b = (n * 7 + 3) % 32;
      if (a == b) b = (b + 1) % 32;
      bad = w ^ (32'd1 << a) ^ (32'd1 << b);
      drive('0, bad, model_check(w));
      chk($countones(rd_fixed ^ bad) <= 1, "R6 at most one inversion",
          64'($countones(rd_fixed ^ bad)), 64'd1);
      chk(!(err_fixed && err_fatal), "R6 flags exclusive",
          {62'd0, err_fixed, err_fatal}, 64'd0);
    end
  endtask

  initial begin
    #750000;
    fails++;
    $display("FAIL watchdog all requirements actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    t_idle();
    t_encode();
    t_clean();
    t_data_flips();
    t_check_flips();
    t_fatal();
    t_double();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule